// File: doc/BRIEF.md
# TDM PCM Receive Slot Extractor

This block pulls per-channel samples out of a serial time-division-multiplexed PCM receive stream. The stream arrives one bit per clock, MSB first, and is grouped into 8-bit slots. A frame-sync input marks each frame. A programmable delay of 0 to 7 clocks places the effective frame start after the detected sync edge. Each of the four channels owns a configuration byte that holds an enable bit and a slot number. When a channel is enabled, it captures the byte carried in its slot.

A global mode input selects between two formats. In companded mode each channel takes one 8-bit slot. In linear mode each channel takes a 16-bit word. The high byte comes from the programmed slot and the low byte from the slot after it. When the programmed slot is the highest one, the low byte comes from slot 0 of the following frame. Each completed sample appears on the channel's 16-bit output together with a one-cycle valid strobe. Decoding of companded samples is left to the logic downstream.

Top module: `tdm_rx_slot_extractor`

## Requirements
- R1: After reset every channel byte and the delay field are 0, all channels are disabled, every sample output is 0 and every strobe is low.
- R2: A write at address i (0 to 3) loads the channel i byte, with bit 7 the enable and bits 6..0 the slot number. A write at address 4 loads the receive delay from bits 2..0. Bits 5..3 at address 4 form a transmit delay field that has no effect on reception. A written value takes effect from the next clock.
- R3: The effective frame start comes S rising clock edges after the edge at which frame sync is first seen high after being low, where S is the delay field. Bit k of the frame is the data input sampled at the falling edge that follows the rising edge k clocks after the frame start. Slot n holds bits 8n to 8n+7, MSB first.
- R4: In companded mode, an enabled channel puts the byte of its slot on sample bits 7..0 with bits 15..8 at zero. Counting from the sync-detect edge, the strobe is high for the one cycle after rising edge S+8L+9, where L is the slot that carries the last bit of the sample.
- R5: In linear mode, an enabled channel with slot p outputs {byte of slot p, byte of slot p+1}, and the strobe follows the R4 timing with L = p+1.
- R6: In linear mode with slot 127, the high byte comes from slot 127 and the low byte from slot 0 of the next frame, with the timing taken from that next frame.
- R7: In linear mode, if the next frame starts before slot p+1 and p is not 127, the channel produces no sample for that frame.
- R8: A disabled channel never raises its strobe and its sample output keeps its previous value.
- R9: A channel whose slot number lies at or beyond the frame length, set by the spacing of frame-sync edges, produces no sample.
- R10: The counters restart at every effective frame start. The strobe lasts exactly one cycle, and each channel gives at most one sample per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; sync sampled on rising edge, data on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync; its rising edge marks a frame |
| rx_data_i | input | 1 | Serial PCM receive data |
| linear_i | input | 1 | 1 = 16-bit linear mode, 0 = 8-bit companded mode |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration address |
| cfg_wdata_i | input | 8 | Configuration write data |
| smp_o | output | 64 | Channel samples, channel i at bits 16i+15..16i |
| smp_vld_o | output | 4 | One-cycle sample strobe per channel |

## Verification
A wrong bit counter or start delay shows up at the ports as a sample that is shifted by some bits, or as a strobe that arrives in the wrong cycle. The bench therefore checks both the value of every sample and the exact cycle in which it arrives, from the very first slot of a frame. A mistake in the pending high-byte state shows up as a missing or extra linear sample one slot later, or in the next frame for the wrap case. Any strobe that the model does not predict is reported in the cycle it happens.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BIT_W  = $clog2(BYTE_W);
   localparam int unsigned EN_BIT = BYTE_W - 1;
   localparam int unsigned SMP_W  = 2 * BYTE_W;
endpackage

// File: rtl/tdm_rx_frame_timer.sv
module tdm_rx_frame_timer
   import tdm_rx_pkg::*;
#(
   parameter int unsigned SLOT_W = 7,
   parameter int unsigned SH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic [SH_W-1:0]   shift_i,
   output logic              start_o,
   output logic              bit_vld_o,
   output logic [BIT_W-1:0]  bit_pos_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam int unsigned IDX_W = SLOT_W + BIT_W + 1;
   localparam int unsigned DLY   = 1 << SH_W;

   logic             fs_q;
   logic             rise;
   logic [DLY-1:0]   rise_sr;
   logic             armed_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] cur_idx;

   assign rise    = fsync_i & ~fs_q;
   assign start_o = rise_sr[shift_i];
   assign cur_idx = start_o ? '0 : idx_q;

   assign bit_vld_o = (armed_q | start_o) & ~cur_idx[IDX_W-1];
   assign bit_pos_o = cur_idx[BIT_W-1:0];
   assign slot_o    = cur_idx[IDX_W-2:BIT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q    <= 1'b0;
         rise_sr <= '0;
         armed_q <= 1'b0;
         idx_q   <= '0;
      end else begin
         fs_q    <= fsync_i;
         rise_sr <= {rise_sr[DLY-2:0], rise};
         if (start_o) armed_q <= 1'b1;
         idx_q   <= (&cur_idx) ? cur_idx : cur_idx + IDX_W'(1);
      end
   end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
   import tdm_rx_pkg::*;
#(
   parameter int unsigned SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din_i,
   input  logic              bit_vld_i,
   input  logic [BIT_W-1:0]  bit_pos_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              start_i,
   output logic              byte_stb_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              start_o
);
   logic              din_n;
   logic [BYTE_W-2:0] sr_q;
   logic              last_bit;

   assign last_bit = bit_vld_i && (bit_pos_i == BIT_W'(BYTE_W - 1));

   always_ff @(negedge clk) din_n <= din_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q       <= '0;
         byte_stb_o <= 1'b0;
         byte_o     <= '0;
         slot_o     <= '0;
         start_o    <= 1'b0;
      end else begin
         start_o    <= start_i;
         byte_stb_o <= last_bit;
         if (bit_vld_i) sr_q <= {sr_q[BYTE_W-3:0], din_n};
         if (last_bit) begin
            byte_o <= {sr_q, din_n};
            slot_o <= slot_i;
         end
      end
   end

   // R3
   byte_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb_o |=> !byte_stb_o);
endmodule

// File: rtl/tdm_rx_cfg.sv
module tdm_rx_cfg
   import tdm_rx_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SH_W   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we_i,
   input  logic [ADDR_W-1:0]     cfg_addr_i,
   input  logic [BYTE_W-1:0]     cfg_wdata_i,
   output logic [NCH*BYTE_W-1:0] cfg_o,
   output logic [SH_W-1:0]       shift_o
);
   logic [BYTE_W-1:0] cfg_q [NCH];
   logic [SH_W-1:0]   shift_q;

   for (genvar i = 0; i < NCH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      cfg_q[i] <= '0;
         else if (cfg_we_i && cfg_addr_i == ADDR_W'(i))  cfg_q[i] <= cfg_wdata_i;
      end
      assign cfg_o[i*BYTE_W +: BYTE_W] = cfg_q[i];

      // R2
      wr_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_we_i && cfg_addr_i == ADDR_W'(i) |=> cfg_o[i*BYTE_W +: BYTE_W] == $past(cfg_wdata_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        shift_q <= '0;
      else if (cfg_we_i && cfg_addr_i == ADDR_W'(NCH))  shift_q <= cfg_wdata_i[SH_W-1:0];
   end
   assign shift_o = shift_q;

   // R2
   wr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i && cfg_addr_i == ADDR_W'(NCH) |=> shift_o == $past(cfg_wdata_i[SH_W-1:0]));
endmodule

// File: rtl/tdm_rx_chan.sv
module tdm_rx_chan
   import tdm_rx_pkg::*;
#(
   parameter int unsigned SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cfg_i,
   input  logic              linear_i,
   input  logic              byte_stb_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              start_i,
   output logic [SMP_W-1:0]  smp_o,
   output logic              vld_o
);
   localparam logic [SLOT_W-1:0] LAST = '1;

   logic              en;
   logic [SLOT_W-1:0] sel;
   logic [SLOT_W-1:0] sel_nx;
   logic              hit_first;
   logic              hit_next;
   logic [BYTE_W-1:0] hi_q;
   logic              hi_ok_q;

   assign en        = cfg_i[EN_BIT];
   assign sel       = cfg_i[SLOT_W-1:0];
   assign sel_nx    = sel + SLOT_W'(1);
   assign hit_first = byte_stb_i && (slot_i == sel);
   assign hit_next  = byte_stb_i && (slot_i == sel_nx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_o   <= '0;
         vld_o   <= 1'b0;
         hi_q    <= '0;
         hi_ok_q <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (start_i && sel != LAST) hi_ok_q <= 1'b0;
         if (!en || !linear_i) begin
            hi_ok_q <= 1'b0;
            if (en && hit_first) begin
               smp_o <= {{BYTE_W{1'b0}}, byte_i};
               vld_o <= 1'b1;
            end
         end else if (hit_first) begin
            hi_q    <= byte_i;
            hi_ok_q <= 1'b1;
         end else if (hit_next && hi_ok_q) begin
            smp_o   <= {hi_q, byte_i};
            vld_o   <= 1'b1;
            hi_ok_q <= 1'b0;
         end
      end
   end

   // R10
   one_cycle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);

   // R4
   comp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o && !$past(linear_i) |-> smp_o[SMP_W-1:BYTE_W] == '0);
endmodule

// File: rtl/tdm_rx_slot_extractor.sv
module tdm_rx_slot_extractor
   import tdm_rx_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned SLOT_W = 7,
   parameter int unsigned SH_W   = 3,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fsync_i,
   input  logic                 rx_data_i,
   input  logic                 linear_i,
   input  logic                 cfg_we_i,
   input  logic [ADDR_W-1:0]    cfg_addr_i,
   input  logic [BYTE_W-1:0]    cfg_wdata_i,
   output logic [NCH*SMP_W-1:0] smp_o,
   output logic [NCH-1:0]       smp_vld_o
);
   if (SLOT_W < 1 || SLOT_W > BYTE_W - 1) begin : g_bad_slot
      $error("SLOT_W must leave room for the enable bit");
   end
   if (SH_W < 1) begin : g_bad_shift
      $error("SH_W must be at least 1");
   end
   if ((1 << ADDR_W) < NCH + 1) begin : g_bad_addr
      $error("ADDR_W too small for NCH channel bytes plus the delay register");
   end

   logic [NCH*BYTE_W-1:0] cfg_w;
   logic [SH_W-1:0]       shift_w;
   logic                  start_w;
   logic                  bit_vld_w;
   logic [BIT_W-1:0]      bit_pos_w;
   logic [SLOT_W-1:0]     slot_w;
   logic                  byte_stb_w;
   logic [BYTE_W-1:0]     byte_w;
   logic [SLOT_W-1:0]     byte_slot_w;
   logic                  start_d_w;

   tdm_rx_cfg #(.NCH(NCH), .ADDR_W(ADDR_W), .SH_W(SH_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_o(cfg_w), .shift_o(shift_w)
   );

   tdm_rx_frame_timer #(.SLOT_W(SLOT_W), .SH_W(SH_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .shift_i(shift_w),
      .start_o(start_w), .bit_vld_o(bit_vld_w), .bit_pos_o(bit_pos_w), .slot_o(slot_w)
   );

   tdm_rx_deser #(.SLOT_W(SLOT_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .din_i(rx_data_i),
      .bit_vld_i(bit_vld_w), .bit_pos_i(bit_pos_w), .slot_i(slot_w), .start_i(start_w),
      .byte_stb_o(byte_stb_w), .byte_o(byte_w), .slot_o(byte_slot_w), .start_o(start_d_w)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tdm_rx_chan #(.SLOT_W(SLOT_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .cfg_i(cfg_w[i*BYTE_W +: BYTE_W]), .linear_i(linear_i),
         .byte_stb_i(byte_stb_w), .byte_i(byte_w), .slot_i(byte_slot_w), .start_i(start_d_w),
         .smp_o(smp_o[i*SMP_W +: SMP_W]), .vld_o(smp_vld_o[i])
      );

      // R8
      off_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
         smp_vld_o[i] |-> $past(cfg_w[i*BYTE_W + EN_BIT]));
   end
endmodule

// File: tb/tdm_rx_slot_extractor_tb.sv
module tdm_rx_slot_extractor_tb;
   localparam int NCH = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fsync = 1'b0;
   logic             rx = 1'b0;
   logic             lin = 1'b0;
   logic             we = 1'b0;
   logic [2:0]       addr = '0;
   logic [7:0]       wdata = '0;
   logic [NCH*16-1:0] smp;
   logic [NCH-1:0]   vld;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int base = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   int    exp_d [NCH][$];
   int    exp_t [NCH][$];
   string exp_g [NCH][$];
   string unexp_tag [NCH];
   logic [7:0] frm [0:3][0:127];

   tdm_rx_slot_extractor u_dut (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .rx_data_i(rx), .linear_i(lin),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .smp_o(smp), .smp_vld_o(vld)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: R2 and R10 are exercised by every matched sample below
   always @(negedge clk) begin
      if (rst_n && running) begin
         for (int c = 0; c < NCH; c++) begin
            if (vld[c]) begin
               if (exp_d[c].size() == 0) begin
                  n_chk++;
                  n_bad++;
                  $display("FAIL %s ch%0d unexpected sample actual=%0h expected=none",
                           unexp_tag[c], c, smp[c*16 +: 16]);
               end else begin
                  int ed;
                  int et;
                  string tg;
                  ed = exp_d[c].pop_front();
                  et = exp_t[c].pop_front();
                  tg = exp_g[c].pop_front();
                  chk(tg, $sformatf("ch%0d data", c), int'(smp[c*16 +: 16]), ed);
                  chk("R3", $sformatf("ch%0d arrival", c), cyc - base, et);
               end
            end
         end
      end
   end

   task automatic session(int nslots, int sh, bit linm, logic [7:0] cf [NCH], int nfr);
      int n;
      int tot;
      n = 8 * nslots;
      running = 1'b0;
      rst_n = 1'b0;
      fsync = 1'b0;
      rx = 1'b0;
      lin = linm;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         chk("R1", $sformatf("ch%0d strobe after reset", c), int'(vld[c]), 0);
         chk("R1", $sformatf("ch%0d sample after reset", c), int'(smp[c*16 +: 16]), 0);
      end
      // R2: channel bytes at 0..3, delay at 4 with random transmit bits in 5..3
      for (int c = 0; c <= NCH; c++) begin
         @(posedge clk);
         #1 we = 1'b1;
         addr = 3'(c);
         wdata = (c < NCH) ? cf[c] : {2'($urandom), 3'($urandom), 3'(sh)};
      end
      @(posedge clk);
      #1 we = 1'b0;
      for (int f = 0; f < nfr; f++)
         for (int s = 0; s < nslots; s++) frm[f][s] = 8'($urandom);
      for (int c = 0; c < NCH; c++) begin
         int p;
         bit en;
         p = int'(cf[c][6:0]);
         en = cf[c][7];
         if (!en)                              unexp_tag[c] = "R8";
         else if (p >= nslots)                 unexp_tag[c] = "R9";
         else if (linm && p == nslots - 1)     unexp_tag[c] = (p == 127) ? "R6" : "R7";
         else                                  unexp_tag[c] = linm ? "R5" : "R4";
         for (int f = 0; f < nfr; f++) begin
            if (en && !linm && p < nslots) begin
               exp_d[c].push_back(int'(frm[f][p]));
               exp_t[c].push_back(f * n + sh + 8 * p + 10);
               exp_g[c].push_back("R4");
            end else if (en && linm && p + 1 < nslots) begin
               exp_d[c].push_back(int'({frm[f][p], frm[f][p+1]}));
               exp_t[c].push_back(f * n + sh + 8 * (p + 1) + 10);
               exp_g[c].push_back("R5");
            end else if (en && linm && p == 127 && nslots == 128 && f + 1 < nfr) begin
               exp_d[c].push_back(int'({frm[f][127], frm[f+1][0]}));
               exp_t[c].push_back((f + 1) * n + sh + 10);
               exp_g[c].push_back("R6");
            end
         end
      end
      tot = nfr * n + sh + 8;
      for (int t = 0; t < tot; t++) begin
         int k;
         @(posedge clk);
         #1;
         if (t == 0) begin
            base = cyc;
            running = 1'b1;
         end
         fsync = (t % n == 0) && (t / n <= nfr);
         k = t - 1 - sh;
         if (k >= 0 && k < nfr * n) rx = frm[k / n][(k % n) / 8][7 - (k % 8)];
         else rx = 1'b0;
      end
      @(negedge clk);
      running = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         chk(exp_g[c].size() > 0 ? exp_g[c][0] : "R10",
             $sformatf("ch%0d samples still missing", c), exp_d[c].size(), 0);
         if (!cf[c][7]) chk("R8", $sformatf("ch%0d held sample", c), int'(smp[c*16 +: 16]), 0);
         exp_d[c].delete();
         exp_t[c].delete();
         exp_g[c].delete();
      end
   endtask

   initial begin
      logic [7:0] cf [NCH];
      void'($urandom(32'd4207));
      // companded, short frame: slot 0, last slot, disabled, slot beyond frame (R9)
      cf = '{8'h80, 8'h87, 8'h03, 8'h89};
      session(8, 0, 1'b0, cf, 3);
      // linear: slot 6 fits, slot 7 is last so no sample (R7), disabled (R8)
      cf = '{8'h80, 8'h86, 8'h87, 8'h02};
      session(8, 5, 1'b1, cf, 3);
      // linear, full frame: wrap from slot 127 into next frame (R6)
      cf = '{8'hFF, 8'hFE, 8'h80, 8'hC0};
      session(128, 7, 1'b1, cf, 2);
      // companded, full frame, highest slot
      cf = '{8'hFF, 8'h80, 8'h05, 8'hC0};
      session(128, 3, 1'b0, cf, 2);
      // linear, tiny frame with delay
      cf = '{8'h83, 8'h82, 8'h85, 8'h81};
      session(4, 2, 1'b1, cf, 3);
      // constrained random sessions
      for (int r = 0; r < 12; r++) begin
         int ns;
         ns = 4 << ($urandom % 5);
         for (int c = 0; c < NCH; c++)
            cf[c] = {1'($urandom), 7'($urandom % (ns + 2))};
         session(ns, int'($urandom % 8), 1'($urandom), cf, 2 + int'($urandom % 2));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule